// File: doc/BRIEF.md
# DDR3 Idle-Current Stimulus Sequencer

This block drives a DDR3 command bus with a fixed, repeating background pattern for measuring idle supply current. The clock keeps toggling and clock enable stays high throughout. Each 32-cycle loop contains only deselect commands. It is built from eight four-cycle sub-loops. Each sub-loop gives two plain deselects followed by two inverted deselects. The bank address steps by one per sub-loop. A mode input selects whether the on-die termination pin stays low or follows a fixed per-sub-loop schedule.

The sequencer has a three-state controller. IDLE drives a quiet plain deselect. RUN repeats loops back to back while the enable input is high. DRAIN finishes a loop whose enable was withdrawn part way through. Its transitions are:
- START: IDLE to RUN when enable is high.
- WRAP: RUN to RUN at the last cycle with enable high.
- STOP: RUN to IDLE at the last cycle with enable low.
- RELEASE: RUN to DRAIN when enable falls before the last cycle.
- RESUME: DRAIN to RUN at the last cycle with enable high again.
- FINISH: DRAIN to IDLE at the last cycle with enable low.

The mode is sampled only when a loop begins. A one-cycle pulse marks the first cycle of every loop, and the current sub-loop index is also driven out.

Top module: `idle_stim_seq`

## Requirements
- R1: Every loop cycle drives cs_n high. Within each four-cycle sub-loop, phases 0 and 1 are plain deselects and phases 2 and 3 are inverted deselects.
- R2: A plain deselect drives ras_n, cas_n and we_n low and addr to 16'h0000.
- R3: An inverted deselect drives ras_n, cas_n and we_n high and addr to 16'h0078, which is bits 6 to 3 set and all other bits clear.
- R4: In loop cycle c (0 to 31), ba and sub_idx both equal c/4, stepping 0 through 7.
- R5: With the latched mode 0 (plain), odt stays low for the whole loop.
- R6: With the latched mode 1 (termination toggling), odt for sub-loops 0 to 7 is 0,0,1,1,0,0,1,1 and stays constant within a sub-loop.
- R7: cke is always 1 and dm is always 0.
- R8: Loops repeat back to back with no gap while run_en is high. A loop begins in the cycle after run_en is sampled high at a clock edge in IDLE. loop_start is high only in cycle 0 of each loop.
- R9: When run_en falls, the current loop still runs to cycle 31. In idle the outputs are a plain deselect with ba = 0, sub_idx = 0, odt = 0 and loop_start = 0.
- R10: A synchronous active-high rst forces the idle outputs on the next edge. A later enable starts again from cycle 0.
- R11: term_mode is sampled only on the edge that begins a loop, so a change in the middle of a loop first affects the next loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run request; loops repeat while high |
| term_mode | input | 1 | 0 = odt held low, 1 = odt schedule |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| odt | output | 1 | On-die termination |
| ba | output | 3 | Bank address |
| addr | output | 16 | Address bus |
| dm | output | 1 | Data mask level |
| cke | output | 1 | Clock enable |
| loop_start | output | 1 | Pulse in cycle 0 of each loop |
| sub_idx | output | 3 | Current sub-loop index |

## Verification
The bench flips term_mode in the middle of a loop. A design that samples the mode continuously would then mix the two odt schedules inside one loop. It drops run_en in the middle of a loop, and separately at exactly the last loop cycle. A design that stops at once would return to idle early, and one with an off-by-one end test would run an extra cycle or loop. It also pulses reset in the middle of a loop and restarts. A counter that does not clear would resume with the wrong bank and the wrong pair phase.

// File: rtl/idle_stim_pkg.sv
package idle_stim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

endpackage

// File: rtl/idle_stim_ctr.sv
module idle_stim_ctr #(
    parameter int CNT_W    = 5,
    parameter int LOOP_LEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LOOP_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (adv) begin
            if (cnt == LAST_IDX) cnt <= '0;
            else                 cnt <= cnt + CNT_W'(1);
        end
    end

    assign last = (cnt == LAST_IDX);

endmodule

// File: rtl/idle_stim_pat.sv
module idle_stim_pat #(
    parameter int                 ADDR_W    = 16,
    parameter int                 BA_W      = 3,
    parameter int                 PH_W      = 2,
    parameter int                 NUM_BANKS = 8,
    parameter int                 NIB_LO    = 3,
    parameter int                 NIB_W     = 4,
    parameter logic [NUM_BANKS-1:0] ODT_SCHED = 8'b1100_1100,
    localparam int                CNT_W     = PH_W + BA_W
) (
    input  logic              active,
    input  logic              mode_q,
    input  logic [CNT_W-1:0]  cnt,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              odt,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    logic [BA_W-1:0] sub;
    logic            inv;

    assign sub = cnt[CNT_W-1:PH_W];
    // upper half of each sub-loop carries the inverted deselect
    assign inv = active && cnt[PH_W-1];

    assign ras_n = inv;
    assign cas_n = inv;
    assign we_n  = inv;
    assign ba    = active ? sub : '0;
    assign odt   = active && mode_q && ODT_SCHED[sub];

    for (genvar b = 0; b < ADDR_W; b++) begin : g_addr
        if (b >= NIB_LO && b < NIB_LO + NIB_W) begin : g_nib
            assign addr[b] = inv;
        end else begin : g_low
            assign addr[b] = 1'b0;
        end
    end

endmodule

// File: rtl/idle_stim_seq.sv
module idle_stim_seq #(
    parameter int                   ADDR_W    = 16,
    parameter int                   NUM_BANKS = 8,
    parameter int                   SUB_LEN   = 4,
    parameter int                   NIB_LO    = 3,
    parameter int                   NIB_W     = 4,
    parameter logic [NUM_BANKS-1:0] ODT_SCHED = 8'b1100_1100,
    localparam int                  BA_W      = $clog2(NUM_BANKS),
    localparam int                  PH_W      = $clog2(SUB_LEN),
    localparam int                  CNT_W     = BA_W + PH_W,
    localparam int                  LOOP_LEN  = SUB_LEN * NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              term_mode,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              odt,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              dm,
    output logic              cke,
    output logic              loop_start,
    output logic [BA_W-1:0]   sub_idx
);
    import idle_stim_pkg::*;

    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             cnt_last;
    logic             active;
    logic             mode_q;
    logic             loop_begin;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // transitions: START, WRAP, STOP, RELEASE, RESUME, FINISH
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (run_en) state_nx = ST_RUN;                   // START
            end
            ST_RUN: begin
                if (cnt_last) state_nx = run_en ? ST_RUN : ST_IDLE; // WRAP / STOP
                else if (!run_en) state_nx = ST_DRAIN;          // RELEASE
            end
            ST_DRAIN: begin
                if (cnt_last) state_nx = run_en ? ST_RUN : ST_IDLE; // RESUME / FINISH
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign active     = (state != ST_IDLE);
    assign loop_begin = (state_nx != ST_IDLE) && ((state == ST_IDLE) || cnt_last);

    // mode latched only at a loop boundary
    always_ff @(posedge clk) begin
        if (rst)             mode_q <= 1'b0;
        else if (loop_begin) mode_q <= term_mode;
    end

    idle_stim_ctr #(
        .CNT_W    (CNT_W),
        .LOOP_LEN (LOOP_LEN)
    ) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (!active),
        .adv   (active),
        .cnt   (cnt),
        .last  (cnt_last)
    );

    logic              p_ras_n, p_cas_n, p_we_n, p_odt;
    logic [BA_W-1:0]   p_ba;
    logic [ADDR_W-1:0] p_addr;

    idle_stim_pat #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .PH_W      (PH_W),
        .NUM_BANKS (NUM_BANKS),
        .NIB_LO    (NIB_LO),
        .NIB_W     (NIB_W),
        .ODT_SCHED (ODT_SCHED)
    ) u_pat (
        .active (active),
        .mode_q (mode_q),
        .cnt    (cnt),
        .ras_n  (p_ras_n),
        .cas_n  (p_cas_n),
        .we_n   (p_we_n),
        .odt    (p_odt),
        .ba     (p_ba),
        .addr   (p_addr)
    );

    // output process
    always_comb begin
        cs_n       = 1'b1;
        cke        = 1'b1;
        dm         = 1'b0;
        ras_n      = p_ras_n;
        cas_n      = p_cas_n;
        we_n       = p_we_n;
        odt        = p_odt;
        ba         = p_ba;
        addr       = p_addr;
        sub_idx    = p_ba;
        loop_start = active && (cnt == '0);
    end

endmodule

// File: rtl/idle_stim_chk.sv
module idle_stim_chk #(
    parameter int ADDR_W = 16,
    parameter int BA_W   = 3,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              active,
    input logic              cnt_last,
    input logic [CNT_W-1:0]  cnt,
    input logic              mode_q,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              odt,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              loop_start,
    input logic [BA_W-1:0]   sub_idx
);
    logic seen = 1'b0;
    always_ff @(posedge clk) seen <= !rst;

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        seen && active && $past(active) && cnt[0] |-> (ras_n == $past(ras_n)) && (addr == $past(addr))); // R1
    AST_PLAIN_LOW: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> !cas_n && !we_n && (addr == '0)); // R2
    AST_INV_HIGH: assert property (@(posedge clk) disable iff (rst)
        ras_n |-> cas_n && we_n && (addr != '0)); // R3
    AST_BANK_STEP: assert property (@(posedge clk) disable iff (rst)
        seen && active && $past(active) && !loop_start && (cnt[1:0] == 2'd0) |-> ba == $past(ba) + BA_W'(1)); // R4
    AST_PLAIN_ODT: assert property (@(posedge clk) disable iff (rst)
        !mode_q |-> !odt); // R5
    AST_ODT_HOLD: assert property (@(posedge clk) disable iff (rst)
        seen && active && $past(active) && (cnt[1:0] != 2'd0) |-> $stable(odt)); // R6
    AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
        loop_start |-> (ba == '0) && (sub_idx == '0) && !ras_n); // R8
    AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (rst)
        seen && $past(active) && !$past(cnt_last) |-> active); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !active |-> !ras_n && !odt && (ba == '0) && !loop_start); // R9
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        seen && active && $past(active) && !loop_start |-> $stable(mode_q)); // R11

endmodule

bind idle_stim_seq idle_stim_chk #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .active     (active),
    .cnt_last   (cnt_last),
    .cnt        (cnt),
    .mode_q     (mode_q),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .odt        (odt),
    .ba         (ba),
    .addr       (addr),
    .loop_start (loop_start),
    .sub_idx    (sub_idx)
);

// File: tb/idle_stim_seq_bench.sv
module idle_stim_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst, run_en, term_mode;
    logic        cs_n, ras_n, cas_n, we_n, odt, dm, cke, loop_start;
    logic [2:0]  ba, sub_idx;
    logic [15:0] addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_stim_seq u_idle_stim_seq (
        .clk (clk), .rst (rst), .run_en (run_en), .term_mode (term_mode),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .odt (odt), .ba (ba), .addr (addr), .dm (dm), .cke (cke),
        .loop_start (loop_start), .sub_idx (sub_idx)
    );

    typedef struct {
        logic [28:0] v;   // cs,ras,cas,we,odt,ba,addr,start,sub
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   armed    = 0;
    bit   done     = 0;

    function automatic logic [28:0] pack(logic r, logic o, logic [2:0] b,
                                         logic [15:0] a, logic s, logic [2:0] si);
        return {1'b1, r, r, r, o, b, a, s, si};
    endfunction

    task automatic push_idle(int n, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.v   = pack(1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd0);
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    // expected loop cycles derived from R1..R8
    task automatic push_loop(bit mode, int first, int cnt, string grp);
        for (int c = first; c < first + cnt; c++) begin
            exp_t        e;
            logic        inv;
            logic [2:0]  sb;
            logic        o;
            string       t;
            inv = (c % 4) >= 2;
            sb  = 3'(c / 4);
            o   = mode && ((c / 4) % 4 >= 2);
            e.v = pack(inv, o, sb, inv ? 16'h0078 : 16'h0000, c == 0, sb);
            if (c == 0)              t = "R8";
            else if (c % 4 == 1)     t = "R1";
            else if (mode)           t = "R6";
            else if (c % 4 == 3)     t = "R5";
            else if (inv)            t = "R3";
            else if (c % 8 == 4)     t = "R4";
            else                     t = "R2";
            e.tag = {grp, "/", t};
            q.push_back(e);
        end
    endtask

    // monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        if (armed && q.size() > 0) begin
            exp_t        e;
            logic [28:0] got;
            e   = q.pop_front();
            got = {cs_n, ras_n, cas_n, we_n, odt, ba, addr, loop_start, sub_idx};
            n_checks++;
            if (got !== e.v) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", e.tag, got, e.v);
            end
            n_checks++;
            if (cke !== 1'b1 || dm !== 1'b0) begin
                n_fail++;
                $display("FAIL R7: cke=%b dm=%b expected cke=1 dm=0", cke, dm);
            end
        end
    end

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; run_en = 1'b0; term_mode = 1'b0;
        push_idle(3, "R10");              // items 0-2 in reset
        push_idle(3, "R9");               // items 3-5 idle
        push_loop(1'b0, 0, 32, "R11");    // items 6-37, mode flip mid-loop ignored
        push_loop(1'b1, 0, 32, "R11");    // items 38-69
        push_loop(1'b1, 0, 32, "R9");     // items 70-101, run_en drops mid-loop
        push_idle(4, "R9");               // items 102-105
        push_loop(1'b0, 0, 10, "R10");    // items 106-115, then reset
        push_idle(2, "R10");              // items 116-117
        push_loop(1'b1, 0, 32, "R10");    // items 118-149 restart from cycle 0
        push_idle(4, "R9");               // items 150-153, stop at last cycle
        for (int s = 0; s < 160; s++) begin
            @(negedge clk); #1;
            if (s == 0) armed = 1;
            case (s)
                3:   begin rst = 1'b0; run_en = 1'b0; end
                6:   begin run_en = 1'b1; term_mode = 1'b0; end
                16:  term_mode = 1'b1;
                76:  run_en = 1'b0;
                106: begin run_en = 1'b1; term_mode = 1'b0; end
                116: rst = 1'b1;
                118: begin rst = 1'b0; term_mode = 1'b1; end
                150: run_en = 1'b0;
                default: ;
            endcase
        end
        if (q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: got %0d leftover items expected 0", q.size());
        end
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule